// File: doc/BRIEF.md
# Cascaded System Clock Divider Tree

This block turns one fast main clock and one low-speed tick into a set of derived clock enables. Every output is a single-cycle enable pulse in the main clock domain, so downstream logic runs on the main clock and qualifies its updates with the pulse. The 32.768 kHz source and two clocks made by the digital blocks arrive as enable pulses in the main domain.

Two variable clocks form a chain. The first divides the main clock. The second divides the output of the first, so the two factors multiply. A wider divider on the main clock produces the processor clock. A sleep tick is taken from a binary prescaler of the low-speed tick, and its rate can be set from 512 Hz down to 1 Hz. Four column clocks each pick one of four sources and then divide that source with their own post-divider.

Software sets every divider and selector through an 8-bit write port with a 3-bit address. A new divider value is held in its register and is loaded only when the running count reaches zero. This means a write never shortens a period that has already started.

Top module: `clkDivTree`

## Requirements
- R1: Address 0, bits [3:0], hold the first variable divider field V1. `var1Tick` pulses once every V1+1 main-clock cycles. A field of 0 gives a pulse on every cycle.
- R2: Address 1, bits [3:0], hold V2. `var2Tick` pulses once every V2+1 pulses of `var1Tick` and only in a cycle where `var1Tick` is high. The slowest setting, V1=V2=15, gives one pulse per 256 cycles.
- R3: Address 2, bits [7:0], hold the processor divider C. `cpuTick` pulses once every C+1 main-clock cycles, which reaches down to one pulse per 256 cycles.
- R4: Address 3, bits [3:0], hold the sleep select S. Values of S above FAST_LOG2 are treated as FAST_LOG2. `sleepTick` is high only together with `slowTick`. It pulses once every 2^(SLOW_LOG2-FAST_LOG2+S) low-speed ticks.
- R5: Address 4+c configures column c. Bits [1:0] pick that column's source: 0 selects `digTick0`, 1 selects `digTick1`, 2 selects `var1Tick` and 3 selects `var2Tick`. `colTick[c]` is high only together with the selected source.
- R6: Bits [5:2] at address 4+c are the column post-divider D. `colTick[c]` pulses once every D+1 pulses of the selected source.
- R7: A divider value written while a count is running takes effect only after the current period ends. The next pulse comes at the old spacing and the pulse after it comes at the new spacing.
- R8: After reset every field is 0. The first enable after reset already produces an output pulse, so the variable, processor and column outputs follow their sources directly. The sleep tick first fires on the 2^(SLOW_LOG2-FAST_LOG2)-th low-speed tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock |
| rstN | input | 1 | Asynchronous reset, active low |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 3 | Register address |
| wrData | input | 8 | Register write data |
| slowTick | input | 1 | Low-speed source enable pulse |
| digTick0 | input | 1 | First digital-block clock enable |
| digTick1 | input | 1 | Second digital-block clock enable |
| var1Tick | output | 1 | First variable clock enable |
| var2Tick | output | 1 | Second, chained variable clock enable |
| cpuTick | output | 1 | Processor clock enable |
| sleepTick | output | 1 | Sleep tick enable |
| colTick | output | 4 | Column clock enables, one per column |

## Verification
The bench builds the block with SLOW_LOG2=10 and FAST_LOG2=4. This keeps the 64-tick base period of the fastest sleep rate and shortens the slowest sleep period to 1024 low-speed ticks. With that setting, both the clamp of out-of-range sleep selects and the longest sleep spacing can be measured in a few thousand cycles. The divider widths stay at their defaults, so the bench also measures the full 256-cycle chain, the 256-cycle processor setting and every column source at its real size.

// File: rtl/clkDivPkg.sv
package clkDivPkg;
  localparam int VAR_W   = 4;
  localparam int CPU_W   = 8;
  localparam int COL_N   = 4;
  localparam int COL_W   = 4;
  localparam int SEL_W   = 2;
  localparam int SLEEP_W = 4;
  localparam int ADDR_W  = 3;
  localparam int DATA_W  = 8;
  localparam int SRC_N   = 1 << SEL_W;

  localparam logic [ADDR_W-1:0] REG_V1    = 3'd0;
  localparam logic [ADDR_W-1:0] REG_V2    = 3'd1;
  localparam logic [ADDR_W-1:0] REG_CPU   = 3'd2;
  localparam logic [ADDR_W-1:0] REG_SLEEP = 3'd3;
  localparam int                COL_BASE  = 4;

  typedef struct packed {
    logic [VAR_W-1:0]                v1Div;
    logic [VAR_W-1:0]                v2Div;
    logic [CPU_W-1:0]                cpuDiv;
    logic [SLEEP_W-1:0]              sleepSel;
    logic [COL_N-1:0][SEL_W-1:0]     colSel;
    logic [COL_N-1:0][COL_W-1:0]     colDiv;
  } divCfg_t;

  typedef struct packed {
    logic       sleepPulse;
    logic [1:0] digTick;
  } ctrlStrobe_t;
endpackage

// File: rtl/clkDivCounter.sv
module clkDivCounter #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         srcTick,
  input  logic [W-1:0] divVal,
  output logic         outTick
);
  logic [W-1:0] cnt;

  assign outTick = srcTick && (cnt == '0);

  // reload only at terminal count: a new divisor never cuts a period short
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        cnt <= '0;
    else if (srcTick) cnt <= (cnt == '0) ? divVal : cnt - 1'b1;
  end
endmodule

// File: rtl/clkDivCtrl.sv
module clkDivCtrl
  import clkDivPkg::*;
#(
  parameter int SLOW_LOG2 = 15,
  parameter int FAST_LOG2 = 9
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              slowTick,
  input  logic              digTick0,
  input  logic              digTick1,
  output divCfg_t           cfg,
  output ctrlStrobe_t       strobe
);
  localparam int BASE_EXP = SLOW_LOG2 - FAST_LOG2;
  localparam int SH_W     = $clog2(SLOW_LOG2 + 1);

  logic [SLOW_LOG2-1:0] pre;
  logic [SLEEP_W-1:0]   effSel;
  logic [SH_W-1:0]      shamt;
  logic [SLOW_LOG2-1:0] mask;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfg <= '0;
    end else if (wrEn) begin
      if (wrAddr == REG_V1)    cfg.v1Div    <= wrData[VAR_W-1:0];
      if (wrAddr == REG_V2)    cfg.v2Div    <= wrData[VAR_W-1:0];
      if (wrAddr == REG_CPU)   cfg.cpuDiv   <= wrData[CPU_W-1:0];
      if (wrAddr == REG_SLEEP) cfg.sleepSel <= wrData[SLEEP_W-1:0];
      for (int c = 0; c < COL_N; c++) begin
        if (wrAddr == ADDR_W'(COL_BASE + c)) begin
          cfg.colSel[c] <= wrData[SEL_W-1:0];
          cfg.colDiv[c] <= wrData[SEL_W +: COL_W];
        end
      end
    end
  end

  // free-running prescaler of the low-speed tick
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         pre <= '0;
    else if (slowTick) pre <= pre + 1'b1;
  end

  always_comb begin
    effSel = (cfg.sleepSel > SLEEP_W'(FAST_LOG2)) ? SLEEP_W'(FAST_LOG2) : cfg.sleepSel;
    shamt  = SH_W'(BASE_EXP) + SH_W'(effSel);
    mask   = ~({SLOW_LOG2{1'b1}} << shamt);
  end

  assign strobe.sleepPulse = slowTick && ((pre & mask) == mask);
  assign strobe.digTick    = {digTick1, digTick0};
endmodule

// File: rtl/clkDivPath.sv
module clkDivPath
  import clkDivPkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  divCfg_t          cfg,
  input  ctrlStrobe_t      strobe,
  output logic             var1Tick,
  output logic             var2Tick,
  output logic             cpuTick,
  output logic             sleepTick,
  output logic [COL_N-1:0] colTick
);
  logic [SRC_N-1:0] srcVec;

  clkDivCounter #(.W(VAR_W)) u_var1 (
    .clk(clk), .rstN(rstN), .srcTick(1'b1), .divVal(cfg.v1Div), .outTick(var1Tick)
  );

  // second stage counts first-stage pulses, so the factors multiply
  clkDivCounter #(.W(VAR_W)) u_var2 (
    .clk(clk), .rstN(rstN), .srcTick(var1Tick), .divVal(cfg.v2Div), .outTick(var2Tick)
  );

  clkDivCounter #(.W(CPU_W)) u_cpu (
    .clk(clk), .rstN(rstN), .srcTick(1'b1), .divVal(cfg.cpuDiv), .outTick(cpuTick)
  );

  assign srcVec    = {var2Tick, var1Tick, strobe.digTick[1], strobe.digTick[0]};
  assign sleepTick = strobe.sleepPulse;

  for (genvar gc = 0; gc < COL_N; gc++) begin : g_col
    logic colSrc;
    assign colSrc = srcVec[cfg.colSel[gc]];
    clkDivCounter #(.W(COL_W)) u_colDiv (
      .clk(clk), .rstN(rstN), .srcTick(colSrc), .divVal(cfg.colDiv[gc]), .outTick(colTick[gc])
    );
  end
endmodule

// File: rtl/clkDivTree.sv
module clkDivTree
  import clkDivPkg::*;
#(
  parameter int SLOW_LOG2 = 15,
  parameter int FAST_LOG2 = 9
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              slowTick,
  input  logic              digTick0,
  input  logic              digTick1,
  output logic              var1Tick,
  output logic              var2Tick,
  output logic              cpuTick,
  output logic              sleepTick,
  output logic [COL_N-1:0]  colTick
);
  divCfg_t     cfg;
  ctrlStrobe_t strobe;

  clkDivCtrl #(.SLOW_LOG2(SLOW_LOG2), .FAST_LOG2(FAST_LOG2)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .slowTick(slowTick), .digTick0(digTick0), .digTick1(digTick1),
    .cfg(cfg), .strobe(strobe)
  );

  clkDivPath u_path (
    .clk(clk), .rstN(rstN), .cfg(cfg), .strobe(strobe),
    .var1Tick(var1Tick), .var2Tick(var2Tick), .cpuTick(cpuTick),
    .sleepTick(sleepTick), .colTick(colTick)
  );
endmodule

// File: rtl/clkDivTreeChk.sv
module clkDivTreeChk
  import clkDivPkg::*;
(
  input logic                        clk,
  input logic                        rstN,
  input logic                        slowTick,
  input logic                        digTick0,
  input logic                        digTick1,
  input logic                        var1Tick,
  input logic                        var2Tick,
  input logic                        cpuTick,
  input logic                        sleepTick,
  input logic [COL_N-1:0]            colTick,
  input logic [COL_N-1:0][SEL_W-1:0] colSel,
  input logic [VAR_W-1:0]            v1Div,
  input logic [CPU_W-1:0]            cpuDiv
);
  logic [SRC_N-1:0] srcVec;
  assign srcVec = {var2Tick, var1Tick, digTick1, digTick0};

  AST_V1_REST: assert property (@(posedge clk) disable iff (!rstN)
    (var1Tick && v1Div != '0) |=> !var1Tick); // R1

  AST_V2_ON_V1: assert property (@(posedge clk) disable iff (!rstN)
    var2Tick |-> var1Tick); // R2

  AST_CPU_REST: assert property (@(posedge clk) disable iff (!rstN)
    (cpuTick && cpuDiv != '0) |=> !cpuTick); // R3

  AST_SLEEP_ON_SLOW: assert property (@(posedge clk) disable iff (!rstN)
    sleepTick |-> slowTick); // R4

  for (genvar gc = 0; gc < COL_N; gc++) begin : g_colChk
    AST_COL_SOURCE: assert property (@(posedge clk) disable iff (!rstN)
      colTick[gc] |-> srcVec[colSel[gc]]); // R5
  end
endmodule

bind clkDivTree clkDivTreeChk u_chk (
  .clk(clk), .rstN(rstN), .slowTick(slowTick), .digTick0(digTick0), .digTick1(digTick1),
  .var1Tick(var1Tick), .var2Tick(var2Tick), .cpuTick(cpuTick), .sleepTick(sleepTick),
  .colTick(colTick), .colSel(cfg.colSel), .v1Div(cfg.v1Div), .cpuDiv(cfg.cpuDiv)
);

// File: tb/clkDivTree_tb.sv
module clkDivTree_tb;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrEn = 1'b0;
  logic [2:0] wrAddr = '0;
  logic [7:0] wrData = '0;
  logic       slowTick = 1'b0;
  logic       digTick0 = 1'b0;
  logic       digTick1 = 1'b0;
  logic       var1Tick, var2Tick, cpuTick, sleepTick;
  logic [3:0] colTick;

  int  testCount = 0;
  int  failCount = 0;
  bit  done = 1'b0;

  clkDivTree #(.SLOW_LOG2(10), .FAST_LOG2(4)) u_dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .slowTick(slowTick), .digTick0(digTick0), .digTick1(digTick1),
    .var1Tick(var1Tick), .var2Tick(var2Tick), .cpuTick(cpuTick),
    .sleepTick(sleepTick), .colTick(colTick)
  );

  always #4 clk = ~clk;

  // source pulses: low-speed every 3 cycles, digital clocks every 5 and 7
  initial begin
    int p3 = 0;
    int p5 = 0;
    int p7 = 0;
    forever begin
      @(posedge clk);
      #1;
      p3 = (p3 + 1) % 3;
      p5 = (p5 + 1) % 5;
      p7 = (p7 + 1) % 7;
      slowTick = (p3 == 0);
      digTick0 = (p5 == 0);
      digTick1 = (p7 == 0);
    end
  end

  task automatic check(input bit ok, input string req, input int actual, input int expected);
    testCount++;
    if (!ok) begin
      failCount++;
      $display("FAIL %s actual=%0d expected=%0d", req, actual, expected);
    end
  endtask

  function automatic logic pick(input int id);
    case (id)
      0: return var1Tick;
      1: return var2Tick;
      2: return cpuTick;
      3: return sleepTick;
      default: return colTick[id-4];
    endcase
  endfunction

  task automatic writeReg(input logic [2:0] addr, input logic [7:0] data);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = addr; wrData = data;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  // cycles between pulses, taken on the third interval so old settings are flushed
  task automatic measure(input int id, output int period);
    int gap;
    period = -1;
    gap = 0;
    while (gap < 20000) begin
      @(negedge clk);
      if (pick(id)) break;
      gap++;
    end
    if (gap >= 20000) return;
    for (int k = 0; k < 3; k++) begin
      gap = 0;
      do begin
        @(negedge clk);
        gap++;
      end while (!pick(id) && gap < 20000);
      if (gap >= 20000) return;
    end
    period = gap;
  endtask

  task automatic testReset();
    int badV1 = 0, badV2 = 0, badCpu = 0, badCol = 0;
    int slowSeen = 0, sleepAt = -1;
    for (int n = 0; n < 250; n++) begin
      @(negedge clk);
      if (!var1Tick) badV1++;
      if (!var2Tick) badV2++;
      if (!cpuTick) badCpu++;
      if (colTick[0] != digTick0) badCol++;
      if (slowTick) begin
        slowSeen++;
        if (sleepTick && sleepAt < 0) sleepAt = slowSeen;
      end
    end
    check(badV1 == 0, "R8 var1 every cycle after reset", badV1, 0);
    check(badV2 == 0, "R8 var2 every cycle after reset", badV2, 0);
    check(badCpu == 0, "R8 cpu every cycle after reset", badCpu, 0);
    check(badCol == 0, "R8 column0 follows digTick0", badCol, 0);
    check(sleepAt == 64, "R8 first sleep tick", sleepAt, 64);
  endtask

  task automatic testVar();
    int p;
    writeReg(3'd0, 8'd2);
    writeReg(3'd1, 8'd3);
    measure(0, p); check(p == 3, "R1 var1 div 3", p, 3);
    measure(1, p); check(p == 12, "R2 var2 chained 3x4", p, 12);
    writeReg(3'd0, 8'd15);
    writeReg(3'd1, 8'd15);
    measure(0, p); check(p == 16, "R1 var1 div 16", p, 16);
    measure(1, p); check(p == 256, "R2 var2 slowest", p, 256);
  endtask

  task automatic testCpu();
    int p;
    writeReg(3'd2, 8'd4);
    measure(2, p); check(p == 5, "R3 cpu div 5", p, 5);
    writeReg(3'd2, 8'hFF);
    measure(2, p); check(p == 256, "R3 cpu div 256", p, 256);
  endtask

  task automatic testSleep();
    int p;
    writeReg(3'd3, 8'd0);
    measure(3, p); check(p == 192, "R4 sleep sel 0", p, 192);
    writeReg(3'd3, 8'd2);
    measure(3, p); check(p == 768, "R4 sleep sel 2", p, 768);
    writeReg(3'd3, 8'd9);
    measure(3, p); check(p == 3072, "R4 sleep sel clamped", p, 3072);
  endtask

  task automatic testColumns();
    int p;
    writeReg(3'd0, 8'd2);
    writeReg(3'd1, 8'd1);
    writeReg(3'd4, 8'((2 << 2) | 0));
    writeReg(3'd5, 8'((0 << 2) | 1));
    writeReg(3'd6, 8'((3 << 2) | 2));
    writeReg(3'd7, 8'((4 << 2) | 3));
    measure(4, p); check(p == 15, "R6 column0 digTick0 div 3", p, 15);
    measure(5, p); check(p == 7, "R5 column1 digTick1", p, 7);
    measure(6, p); check(p == 12, "R5 column2 var1 div 4", p, 12);
    measure(7, p); check(p == 30, "R6 column3 var2 div 5", p, 30);
  endtask

  task automatic testRetune();
    int p, first, second;
    first = -1; second = -1;
    writeReg(3'd0, 8'd7);
    measure(0, p);
    for (int k = 1; k <= 20; k++) begin
      @(negedge clk);
      if (k == 1) begin wrEn = 1'b1; wrAddr = 3'd0; wrData = 8'd1; end
      if (k == 2) wrEn = 1'b0;
      if (var1Tick) begin
        if (first < 0) first = k;
        else if (second < 0) second = k;
      end
    end
    check(first == 8, "R7 old period completes", first, 8);
    check(second == 10, "R7 new period after reload", second, 10);
  endtask

  initial begin
    #1_400_000;
    if (!done) begin
      testCount++;
      failCount++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", testCount, failCount);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    rstN = 1'b1;
    testReset();
    testVar();
    testCpu();
    testSleep();
    testColumns();
    testRetune();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end
endmodule